// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single read or write transactions on a two-wire PHY management bus. A host request carries a direction bit, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block divides the system clock to make the management clock (MDC) and drives the shared data line (MDIO) through an output-enable. Each transaction has the same shape: a preamble of ones, a start code, an opcode, the two addresses, a two-bit turnaround, and a 16-bit data field.

On a read the block releases the line for the turnaround. It samples the second turnaround bit as an error indicator, then shifts in 16 data bits. When that indicator is set, the block returns zero in place of the sampled data. On a write the block keeps driving the line through the turnaround and the data field. When either kind of transaction ends, the block retakes the line and pulses done for one cycle. MDC produces no further edge at that point.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, mdc_o is 0, mdio_oe_o is 1, mdio_o is 0, busy_o is 0 and done_o is 0.
- R2: A transaction starts with 32 MDC periods in which mdio_oe_o is 1 and mdio_o is 1 at every MDC rising edge.
- R3: After the preamble, 14 header bits go out MSB first, one per MDC rising edge: start 01, opcode 10 for a read (rd_i=1) or 01 for a write (rd_i=0), the PHY address, then the register address.
- R4: MDC is high for HALF_CLKS system clocks and low for HALF_CLKS system clocks. mdio_o and mdio_oe_o change only in the clock where MDC falls or where the transaction starts, so they are stable for at least HALF_CLKS clocks before every MDC rising edge (HALF_CLKS >= 2).
- R5: On a read, mdio_oe_o is 0 from MDC period 46 (counting from 0) to the end. The error indicator is the value of mdio_i in the last system clock before the rising edge of period 47.
- R6: On a read, 16 data bits are taken MSB first from mdio_i. Each is taken in the last system clock before the rising edge of MDC periods 48 to 63, and the result appears on rd_data_o.
- R7: If the read error indicator is 1, err_o is 1 and rd_data_o is 0. Otherwise err_o is 0.
- R8: On a write, mdio_oe_o stays 1 for all 64 periods. The turnaround bits 1 then 0 are followed by wr_data_i MSB first.
- R9: done_o pulses for one clock exactly 128*HALF_CLKS clocks after the accepting clock edge. busy_o is 1 from the accept until that pulse. In the done cycle mdio_oe_o is 1 and mdc_o is 0. rd_data_o and err_o update only then, and a write sets both to 0.
- R10: A request is accepted only while idle. A request made while busy_o is 1 does not change the frame in progress and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 16 | Read result, zero when the error indicator was set |
| err_o | output | 1 | Error indicator of the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output-enable |
| mdio_i | input | 1 | Data line input |

## Verification
The assertions check several rules on every cycle. The data line is stable around each MDC rising edge. The line is released while read bits are sampled. done is a single pulse that lands with MDC low and the line retaken. A flagged read reports zero, and the latched frame stays fixed while busy. Other properties can only be shown by the bench scenarios, which use a PHY model: the exact bit order of the preamble, header, turnaround and data, the sampling slot of the error indicator and the data bits, and the full transaction length. The same holds for requests made while busy being ignored at the pins.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_SLOTS  = 32;
  localparam int HDR_SLOTS  = 4 + 2 * ADDR_W;
  localparam int TA_SLOTS   = 2;
  localparam int FRAME_W    = HDR_SLOTS + TA_SLOTS + DATA_W;
  localparam int TOTAL_SLOTS = PRE_SLOTS + FRAME_W;
  localparam int SLOT_W     = $clog2(TOTAL_SLOTS);
  localparam int TA_FIRST   = PRE_SLOTS + HDR_SLOTS;
  localparam int ERR_SLOT   = TA_FIRST + 1;
  localparam int DATA_FIRST = TA_FIRST + TA_SLOTS;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    return {SOF_BITS, (rd ? OP_READ : OP_WRITE), phy, ra, TA_WRITE, wd};
  endfunction
endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             high_q;
  logic             last;

  assign last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      high_q <= ~high_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = high_q;
  assign rise_o = run_i && last && !high_q;
  assign fall_o = run_i && last && high_q;

  AST_PHASE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R4
  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o); // R1
endmodule

// File: rtl/mdio_slot_ctr.sv
module mdio_slot_ctr import mdio_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (start_i) slot_q <= '0;
    else if (step_i)  slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  assign last_o = step_i && (slot_q == SLOT_W'(TOTAL_SLOTS - 1));

  AST_SLOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (slot_o == '0)); // R2
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture import mdio_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              mdio_i,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o
);
  logic              err_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      sh_q  <= '0;
    end else if (clear_i) begin
      err_q <= 1'b0;
      sh_q  <= '0;
    end else if (sample_i) begin
      if (slot_i == SLOT_W'(ERR_SLOT)) err_q <= mdio_i;
      if (slot_i >= SLOT_W'(DATA_FIRST)) sh_q <= {sh_q[DATA_W-2:0], mdio_i};
    end
  end

  assign err_o  = err_q;
  assign data_o = sh_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master import mdio_pkg::*; #(
  parameter int HALF_CLKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int FIDX_W = $clog2(FRAME_W);

  state_e               state_q;
  logic                 rd_q;
  logic [FRAME_W-1:0]   frame_q;
  logic                 done_q;
  logic                 err_q;
  logic [DATA_W-1:0]    rd_data_q;
  logic                 accept, run;
  logic                 rise, fall, last;
  logic [SLOT_W-1:0]    slot;
  logic                 cap_err;
  logic [DATA_W-1:0]    cap_data;
  logic [SLOT_W-1:0]    fidx;
  logic                 host_bit, released;

  assign accept = req_i && (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);

  mdio_phase_gen #(.HALF_CLKS(HALF_CLKS)) i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_slot_ctr i_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .step_i (fall),
    .slot_o (slot),
    .last_o (last)
  );

  mdio_rx_capture i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .sample_i(rise && rd_q),
    .slot_i  (slot),
    .mdio_i  (mdio_i),
    .err_o   (cap_err),
    .data_o  (cap_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_q      <= 1'b0;
      frame_q   <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rd_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        rd_q    <= rd_i;
        frame_q <= build_frame(rd_i, phy_addr_i, reg_addr_i, wr_data_i);
      end else if (run && last) begin
        state_q   <= ST_IDLE;
        done_q    <= 1'b1;
        err_q     <= rd_q && cap_err;
        rd_data_q <= (rd_q && !cap_err) ? cap_data : '0;
      end
    end
  end

  // Bus drive decoded from slot; changes only when the slot advances (MDC fall)
  always_comb begin
    fidx     = SLOT_W'(TOTAL_SLOTS - 1) - slot;
    host_bit = (slot < SLOT_W'(PRE_SLOTS)) ? 1'b1 : frame_q[fidx[FIDX_W-1:0]];
    released = run && rd_q && (slot >= SLOT_W'(TA_FIRST));
  end

  assign mdio_oe_o = !released;
  assign mdio_o    = run && !released && host_bit;
  assign busy_o    = run;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rd_data_o = rd_data_q;

  AST_SETUP_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R4
  AST_HOLD_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |=> ($stable(mdio_o) && $stable(mdio_oe_o))); // R4
  AST_RELEASED_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && rd_q && (slot >= SLOT_W'(TA_FIRST))) |-> !mdio_oe_o); // R5
  AST_ERR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rd_data_o == '0)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_HANDBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mdc_o && mdio_oe_o)); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(frame_q))); // R10
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 4;
  localparam int CLK_NS = 20;
  localparam int TXN_CYC = 128 * HALF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rd_data_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  mdio_master #(.HALF_CLKS(HALF)) i_mdio_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o), .err_o(err_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model and bus monitor
  logic [15:0] phy_resp = '0;
  logic        phy_err = 1'b0;
  logic        cap_o [64];
  logic        cap_oe [64];
  int          rise_cnt = 0;
  time         t_chg = 0, t_rise = 0;
  time         min_setup = 1000000;
  int          width_bad = 0;

  function automatic logic phy_bit(int s);
    if (s == 47) return phy_err;
    if (s >= 48) return phy_resp[63 - s];
    return 1'b1;
  endfunction

  always @(mdio_o or mdio_oe_o) t_chg = $time;

  always @(posedge mdc_o or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt = 0;
      mdio_i = 1'b1;
    end else begin
      t_rise = $time;
      if ($time - t_chg < min_setup) min_setup = $time - t_chg;
      cap_o[rise_cnt]  = mdio_o;
      cap_oe[rise_cnt] = mdio_oe_o;
      rise_cnt = (rise_cnt + 1) % 64;
      mdio_i = phy_bit(rise_cnt);
    end
  end

  always @(negedge mdc_o) if (rst_ni && ($time - t_rise != HALF * CLK_NS)) width_bad++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] resp,
                         input logic eb, input bit busy_req);
    int cyc;
    int dones;
    int bad;
    logic [13:0] hdr;
    logic [15:0] exp_rd;
    logic [15:0] prev_rd;
    logic        prev_err;
    phy_resp = resp;
    phy_err  = eb;
    @(negedge clk_i);
    req_i = 1'b1; rd_i = rd; phy_addr_i = phy; reg_addr_i = ra; wr_data_i = wd;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R9", "busy after accept", 32'(busy_o), 1);
    if (busy_req) begin
      rd_i = ~rd; phy_addr_i = ~phy; reg_addr_i = ~ra; wr_data_i = ~wd;
    end else req_i = 1'b0;
    prev_rd = rd_data_o; prev_err = err_o;
    cyc = 0; dones = 0;
    while (cyc < TXN_CYC + 100) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 20) req_i = 1'b0;
      if (!done_o && (rd_data_o != prev_rd || err_o != prev_err)) dones = 1000;
      if (done_o) break;
    end
    chk(cyc == TXN_CYC, "R9", "done latency", 32'(cyc), 32'(TXN_CYC));
    chk(dones == 0, "R9", "results held while busy", 32'(dones), 0);
    chk(!mdc_o && mdio_oe_o && !busy_o, "R9", "handback at done",
        {29'd0, mdc_o, mdio_oe_o, busy_o}, 32'b010);
    exp_rd = (rd && !eb) ? resp : 16'h0;
    if (rd) begin
      chk(rd_data_o == exp_rd, eb ? "R7" : "R6", "read data", 32'(rd_data_o), 32'(exp_rd));
      chk(err_o == eb, "R7", "error flag", 32'(err_o), 32'(eb));
    end else begin
      chk(rd_data_o == 16'h0 && err_o == 1'b0, "R9", "write clears result",
          {15'd0, err_o, rd_data_o}, 0);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0 && rd_data_o == exp_rd, "R9", "done single pulse, data held",
        {15'd0, done_o, rd_data_o}, {16'd0, exp_rd});
    bad = 0;
    for (int s = 0; s < 32; s++) if (!cap_o[s] || !cap_oe[s]) bad++;
    chk(bad == 0, "R2", "preamble bits", 32'(bad), 0);
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
    bad = 0;
    for (int s = 32; s < 46; s++) if (cap_o[s] !== hdr[45 - s] || !cap_oe[s]) bad++;
    chk(bad == 0, "R3", "header bits", 32'(bad), 0);
    bad = 0;
    if (rd) begin
      for (int s = 46; s < 64; s++) if (cap_oe[s]) bad++;
      chk(bad == 0, "R5", "line released on read", 32'(bad), 0);
    end else begin
      for (int s = 46; s < 64; s++) begin
        if (!cap_oe[s]) bad++;
        if (cap_o[s] !== ((s == 46) ? 1'b1 : (s == 47) ? 1'b0 : wd[63 - s])) bad++;
      end
      chk(bad == 0, "R8", "write turnaround and data", 32'(bad), 0);
    end
  endtask

  // rd, phy, reg, wdata, phy response, error bit
  localparam logic [43:0] VEC [7] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000, 1'b0},
    {1'b1, 5'h1f, 5'h1f, 16'h0000, 16'hA5C3, 1'b0},
    {1'b1, 5'h00, 5'h02, 16'h0000, 16'hFFFF, 1'b1},
    {1'b0, 5'h15, 5'h0a, 16'hFFFF, 16'h0000, 1'b0},
    {1'b1, 5'h0a, 5'h15, 16'h0000, 16'h0001, 1'b0},
    {1'b1, 5'h10, 5'h01, 16'h0000, 16'h8000, 1'b0},
    {1'b0, 5'h00, 5'h1f, 16'h0000, 16'h0000, 1'b0}
  };

  initial begin
    int extra;
    repeat (3) @(negedge clk_i);
    chk(!mdc_o && mdio_oe_o && !mdio_o && !busy_o && !done_o, "R1", "in reset",
        {27'd0, mdc_o, mdio_oe_o, mdio_o, busy_o, done_o}, 32'b01000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!mdc_o && mdio_oe_o && !mdio_o && !busy_o && rd_data_o == 0 && !err_o, "R1",
        "idle after reset", {27'd0, mdc_o, mdio_oe_o, mdio_o, busy_o, err_o}, 32'b01000);

    for (int i = 0; i < 7; i++)
      run_txn(VEC[i][43], VEC[i][42:38], VEC[i][37:33], VEC[i][32:17],
              VEC[i][16:1], VEC[i][0], 1'b0);

    // R10: requests held asserted with other fields while busy
    run_txn(1'b0, 5'h03, 5'h04, 16'hBEEF, 16'h0, 1'b0, 1'b1);
    extra = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (done_o || busy_o) extra++;
    end
    chk(extra == 0, "R10", "no extra transaction", 32'(extra), 0);
    chk(!mdc_o && mdio_oe_o && !mdio_o, "R1", "idle after transactions",
        {29'd0, mdc_o, mdio_oe_o, mdio_o}, 32'b010);
    chk(min_setup >= HALF * CLK_NS, "R4", "data setup before MDC rise",
        32'(min_setup), 32'(HALF * CLK_NS));
    chk(width_bad == 0, "R4", "MDC high width", 32'(width_bad), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule